// File: doc/BRIEF.md
# Dual-Thread Core Low-Power State Controller

This block tracks the power state of a processor core that runs two hardware threads. Each thread reports, through a one-cycle strobe, that it has executed a halt or monitor-wait instruction. That thread is then marked as parked while the other thread keeps running. Only when every thread is parked does the core as a whole drop from its running state into HALT. On that transition the block issues a one-cycle halt bus-cycle pulse.

Several inputs move the core between states. Wake events (system-management interrupt, init, bus-init, NMI, INTR and bus-delivered interrupts) bring a halted core back to running. An active-low stop-clock request moves the core into Stop-Grant, and releasing it returns the core to whichever state it came from. Snoop requests in HALT or Stop-Grant enter a dedicated snoop sub-state, which returns to its own parent once the snoop-done strobe arrives. When a management-mode handler finishes, a resume strobe with a target select can send the core straight back to HALT.

The outputs are the registered state code, the per-thread parked flags, the halt bus-cycle pulse, an internal clock-gate enable and a snoop-service enable. The reset is asynchronous on assertion and released through a synchronizer.

Top module: `core_lp_fsm`

## Requirements
- R1: While `rst_n` is low, and after its synchronised release with quiet inputs, `state_o` is 0 (running), `thr_parked_o` is all zero, `halt_bus_cyc_o` is 0, `clk_gate_en_o` is 1 and `snoop_svc_en_o` is 0. Assertion of `rst_n` acts without waiting for a clock edge.
- R2: In the running state (code 0), a strobe on `thr_halt_i[i]` sets only `thr_parked_o[i]`. Flags already set stay set. The state stays 0 while any thread's flag stays clear.
- R3: In the running state, with stop-clock released and no wake event, the state becomes HALT (code 1) on the edge where every thread's flag is set or being set. `halt_bus_cyc_o` is high for exactly the first cycle of that HALT.
- R4: The wake inputs are `wk_smi_i`, `wk_init_i`, `wk_businit_i`, `wk_nmi_i`, `wk_intr_i` and `wk_busirq_i`. Any of them high in HALT moves the core to code 0 and clears all flags. Any of them high in the running state clears all flags, and this beats a halt strobe in the same cycle.
- R5: `snp_req_i` in HALT gives HALT-snoop (code 2). `snp_done_i` there returns the core to HALT.
- R6: `stopclk_req_n` low in the running state or in HALT gives Stop-Grant (code 3). In the running state it beats halt entry. In HALT a wake event beats it. `stopclk_req_n` high in Stop-Grant returns the core to the state it was entered from.
- R7: `snp_req_i` in Stop-Grant gives Stop-Grant-snoop (code 4), and `snp_done_i` returns the core to Stop-Grant. The stop-clock level has no effect in that snoop state.
- R8: In the running state, with stop-clock released, no wake event and the core not entering HALT by R3, a `rsm_i` strobe with `rsm_to_halt_i`=1 moves the core to HALT and sets every flag, with no bus-cycle pulse. With `rsm_to_halt_i`=0 the strobe has no effect.
- R9: `clk_gate_en_o` is 0 exactly in codes 1 and 3. `snoop_svc_en_o` is 1 exactly in codes 2 and 4.
- R10: Halt strobes have no effect outside code 0. Wake events have no effect in codes 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, kept running in every state |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_halt_i | input | NTHR | Per-thread halt/monitor-wait strobe |
| stopclk_req_n | input | 1 | Active-low stop-clock request level |
| snp_req_i | input | 1 | Snoop request strobe |
| snp_done_i | input | 1 | Snoop serviced strobe |
| wk_smi_i | input | 1 | Management interrupt wake |
| wk_init_i | input | 1 | Init wake |
| wk_businit_i | input | 1 | Bus-init wake |
| wk_nmi_i | input | 1 | NMI wake |
| wk_intr_i | input | 1 | INTR wake |
| wk_busirq_i | input | 1 | Bus-delivered interrupt wake |
| rsm_i | input | 1 | Management handler resume strobe |
| rsm_to_halt_i | input | 1 | Resume target: 1 = HALT, 0 = running |
| state_o | output | 3 | State code (0..4) |
| thr_parked_o | output | NTHR | Per-thread parked flags |
| halt_bus_cyc_o | output | 1 | One-cycle halt bus-cycle pulse |
| clk_gate_en_o | output | 1 | Internal clock enable |
| snoop_svc_en_o | output | 1 | Snoop service enable |

## Verification
Every result except the reset is due exactly one clock edge after the inputs that cause it: the state, the flags and the bus-cycle pulse are registered, and the two enables decode the registered state with no further delay. The bench drives inputs on the falling edge and advances its reference model by one step for that rising edge. It compares all five outputs at the next falling edge, so each comparison lines up with the single register stage. Reset is checked shortly after `rst_n` falls, without a clock edge. After release, the bench waits out the synchronizer stages with quiet inputs before the model resumes.

// File: rtl/lp_pkg.sv
`timescale 1ns/1ps
package lp_pkg;
  typedef enum logic [2:0] {
    LP_RUN      = 3'd0,
    LP_HALT     = 3'd1,
    LP_HALT_SNP = 3'd2,
    LP_STPG     = 3'd3,
    LP_STPG_SNP = 3'd4
  } lp_state_e;
endpackage

// File: rtl/lp_rst_sync.sv
`timescale 1ns/1ps
module lp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/lp_wake_merge.sv
`timescale 1ns/1ps
module lp_wake_merge #(
  parameter int NEV = 6
) (
  input  logic [NEV-1:0] ev_i,
  output logic           any_o
);
  assign any_o = |ev_i;
endmodule

// File: rtl/lp_thread_track.sv
`timescale 1ns/1ps
module lp_thread_track #(
  parameter int NTHR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] strobe_i,
  input  logic            set_en_i,
  input  logic            set_all_i,
  input  logic            clr_i,
  output logic [NTHR-1:0] flag_o,
  output logic            all_nxt_o
);
  logic [NTHR-1:0] flag_q;
  logic [NTHR-1:0] flag_d;

  for (genvar i = 0; i < NTHR; i++) begin : g_thr
    always_comb begin
      if (clr_i)          flag_d[i] = 1'b0;
      else if (set_all_i) flag_d[i] = 1'b1;
      else                flag_d[i] = flag_q[i] | (set_en_i & strobe_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_all_i && !(set_en_i && strobe_i[i])) |=> (flag_q[i] == $past(flag_q[i]))); // R2
  end

  assign flag_o    = flag_q;
  assign all_nxt_o = &(flag_q | (strobe_i & {NTHR{set_en_i}}));
endmodule

// File: rtl/core_lp_fsm.sv
`timescale 1ns/1ps
module core_lp_fsm
  import lp_pkg::*;
#(
  parameter int NTHR        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] thr_halt_i,
  input  logic            stopclk_req_n,
  input  logic            snp_req_i,
  input  logic            snp_done_i,
  input  logic            wk_smi_i,
  input  logic            wk_init_i,
  input  logic            wk_businit_i,
  input  logic            wk_nmi_i,
  input  logic            wk_intr_i,
  input  logic            wk_busirq_i,
  input  logic            rsm_i,
  input  logic            rsm_to_halt_i,
  output logic [2:0]      state_o,
  output logic [NTHR-1:0] thr_parked_o,
  output logic            halt_bus_cyc_o,
  output logic            clk_gate_en_o,
  output logic            snoop_svc_en_o
);
  localparam int NWAKE = 6;

  logic            srst_n;
  logic            wake_any;
  logic            all_nxt;
  logic [NTHR-1:0] thr_q;
  lp_state_e       state_q, state_d;
  logic            from_halt_q, from_halt_d, from_halt_en;
  logic            pulse_d, pulse_q;
  logic            set_en, set_all, clr;

  lp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  lp_wake_merge #(.NEV(NWAKE)) u_wake (
    .ev_i({wk_busirq_i, wk_intr_i, wk_nmi_i, wk_businit_i, wk_init_i, wk_smi_i}),
    .any_o(wake_any)
  );

  lp_thread_track #(.NTHR(NTHR)) u_thr (
    .clk(clk), .rst_n(srst_n), .strobe_i(thr_halt_i),
    .set_en_i(set_en), .set_all_i(set_all), .clr_i(clr),
    .flag_o(thr_q), .all_nxt_o(all_nxt)
  );

  assign set_en = (state_q == LP_RUN);
  assign clr    = wake_any && (state_q == LP_RUN || state_q == LP_HALT);

  always_comb begin
    state_d      = state_q;
    from_halt_d  = from_halt_q;
    from_halt_en = 1'b0;
    pulse_d      = 1'b0;
    set_all      = 1'b0;
    unique case (state_q)
      LP_RUN: begin
        if (!stopclk_req_n) begin
          state_d      = LP_STPG;
          from_halt_d  = 1'b0;
          from_halt_en = 1'b1;
        end else if (wake_any) begin
          state_d = LP_RUN;
        end else if (all_nxt) begin
          state_d = LP_HALT;
          pulse_d = 1'b1;
        end else if (rsm_i && rsm_to_halt_i) begin
          state_d = LP_HALT;
          set_all = 1'b1;
        end
      end
      LP_HALT: begin
        if (wake_any) begin
          state_d = LP_RUN;
        end else if (!stopclk_req_n) begin
          state_d      = LP_STPG;
          from_halt_d  = 1'b1;
          from_halt_en = 1'b1;
        end else if (snp_req_i) begin
          state_d = LP_HALT_SNP;
        end
      end
      LP_HALT_SNP: if (snp_done_i) state_d = LP_HALT;
      LP_STPG: begin
        if (stopclk_req_n)  state_d = from_halt_q ? LP_HALT : LP_RUN;
        else if (snp_req_i) state_d = LP_STPG_SNP;
      end
      LP_STPG_SNP: if (snp_done_i) state_d = LP_STPG;
      default: state_d = LP_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= LP_RUN;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)           from_halt_q <= 1'b0;
    else if (from_halt_en) from_halt_q <= from_halt_d;
  end

  assign state_o        = state_q;
  assign thr_parked_o   = thr_q;
  assign halt_bus_cyc_o = pulse_q;
  assign clk_gate_en_o  = !(state_q == LP_HALT || state_q == LP_STPG);
  assign snoop_svc_en_o = (state_q == LP_HALT_SNP || state_q == LP_STPG_SNP);

  AST_PULSE_IN_FULL_HALT: assert property (@(posedge clk) disable iff (!srst_n)
    halt_bus_cyc_o |-> (state_q == LP_HALT && (&thr_q))); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!srst_n)
    halt_bus_cyc_o |=> !halt_bus_cyc_o); // R3
  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == LP_HALT && wake_any) |=> (state_q == LP_RUN && thr_q == '0)); // R4
  AST_HSNP_BACK: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == LP_HALT_SNP && snp_done_i) |=> (state_q == LP_HALT)); // R5
  AST_SG_BACK: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == LP_STPG && stopclk_req_n) |=>
      (state_q == ($past(from_halt_q) ? LP_HALT : LP_RUN))); // R6
  AST_SGSNP_BACK: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == LP_STPG_SNP && snp_done_i) |=> (state_q == LP_STPG)); // R7
  AST_SNP_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == LP_STPG_SNP && !snp_done_i) |=> (state_q == LP_STPG_SNP)); // R10
endmodule

// File: tb/core_lp_fsm_test.sv
`timescale 1ns/1ps
module core_lp_fsm_test;
  localparam int NTHR = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NTHR-1:0] thr_halt_i;
  logic            stopclk_req_n, snp_req_i, snp_done_i;
  logic [5:0]      wk;
  logic            rsm_i, rsm_to_halt_i;
  logic [2:0]      state_o;
  logic [NTHR-1:0] thr_parked_o;
  logic            halt_bus_cyc_o, clk_gate_en_o, snoop_svc_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // model state
  int              m_st;
  logic [NTHR-1:0] m_fl;
  logic            m_fh;
  logic            m_pl;
  string           m_tag;

  always #10 clk = ~clk;

  core_lp_fsm #(.NTHR(NTHR)) uut (
    .clk(clk), .rst_n(rst_n), .thr_halt_i(thr_halt_i),
    .stopclk_req_n(stopclk_req_n), .snp_req_i(snp_req_i), .snp_done_i(snp_done_i),
    .wk_smi_i(wk[0]), .wk_init_i(wk[1]), .wk_businit_i(wk[2]),
    .wk_nmi_i(wk[3]), .wk_intr_i(wk[4]), .wk_busirq_i(wk[5]),
    .rsm_i(rsm_i), .rsm_to_halt_i(rsm_to_halt_i),
    .state_o(state_o), .thr_parked_o(thr_parked_o), .halt_bus_cyc_o(halt_bus_cyc_o),
    .clk_gate_en_o(clk_gate_en_o), .snoop_svc_en_o(snoop_svc_en_o)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_gate(input int st);
    return (st == 1 || st == 3) ? 0 : 1;
  endfunction

  function automatic int exp_snp(input int st);
    return (st == 2 || st == 4) ? 1 : 0;
  endfunction

  task automatic step_model(input logic [NTHR-1:0] th, input logic sc_n, input logic sr,
                            input logic sd, input logic [5:0] w, input logic rs, input logic rth);
    logic any_w;
    int   nst;
    any_w = |w;
    nst   = m_st;
    m_pl  = 1'b0;
    m_tag = "R2";
    case (m_st)
      0: begin
        if (!sc_n) begin
          nst = 3; m_fh = 1'b0; m_tag = "R6";
        end else if (any_w) begin
          m_tag = "R4";
        end else if (&(m_fl | th)) begin
          nst = 1; m_pl = 1'b1; m_tag = "R3";
        end else if (rs && rth) begin
          nst = 1; m_tag = "R8";
        end else if (rs) begin
          m_tag = "R8";
        end
        if (any_w) m_fl = '0;
        else if (sc_n && !(&(m_fl | th)) && rs && rth) m_fl = '1;
        else m_fl = m_fl | th;
      end
      1: begin
        m_tag = (th != 0) ? "R10" : "R3";
        if (any_w) begin
          nst = 0; m_fl = '0; m_tag = "R4";
        end else if (!sc_n) begin
          nst = 3; m_fh = 1'b1; m_tag = "R6";
        end else if (sr) begin
          nst = 2; m_tag = "R5";
        end
      end
      2: begin
        m_tag = (any_w || th != 0) ? "R10" : "R5";
        if (sd) nst = 1;
      end
      3: begin
        m_tag = (any_w || th != 0) ? "R10" : "R7";
        if (sc_n) begin
          nst = m_fh ? 1 : 0; m_tag = "R6";
        end else if (sr) begin
          nst = 4;
        end
      end
      default: begin
        m_tag = (any_w || th != 0) ? "R10" : "R7";
        if (sd) nst = 3;
      end
    endcase
    m_st = nst;
  endtask

  task automatic check_all();
    chk(m_tag, int'(state_o), m_st, "state");
    chk((m_tag == "R4") ? "R4" : "R2", int'(thr_parked_o), int'(m_fl), "parked flags");
    chk("R3", int'(halt_bus_cyc_o), int'(m_pl), "halt bus pulse");
    chk("R9", int'(clk_gate_en_o), exp_gate(m_st), "clock gate enable");
    chk("R9", int'(snoop_svc_en_o), exp_snp(m_st), "snoop enable");
  endtask

  task automatic cyc(input logic [NTHR-1:0] th, input logic sc_n, input logic sr,
                     input logic sd, input logic [5:0] w, input logic rs, input logic rth);
    thr_halt_i = th; stopclk_req_n = sc_n; snp_req_i = sr; snp_done_i = sd;
    wk = w; rsm_i = rs; rsm_to_halt_i = rth;
    step_model(th, sc_n, sr, sd, w, rs, rth);
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic quiet();
    thr_halt_i = '0; stopclk_req_n = 1'b1; snp_req_i = 1'b0; snp_done_i = 1'b0;
    wk = '0; rsm_i = 1'b0; rsm_to_halt_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    quiet();
    rst_n = 1'b0;
    #2;
    chk("R1", int'(state_o), 0, "state in reset");
    chk("R1", int'(thr_parked_o), 0, "flags in reset");
    chk("R1", int'(halt_bus_cyc_o), 0, "pulse in reset");
    chk("R1", int'(clk_gate_en_o), 1, "gate in reset");
    chk("R1", int'(snoop_svc_en_o), 0, "snoop in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_st = 0; m_fl = '0; m_fh = 1'b0; m_pl = 1'b0; m_tag = "R1";
    check_all();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic sc_lvl;
    void'($urandom(32'd20240611));
    quiet();
    rst_n = 1'b1;
    #3;
    do_reset();

    // directed: one thread parks (R2), second strobe ignored? no, both -> HALT (R3)
    cyc(2'b01, 1, 0, 0, 6'd0, 0, 0);       // R2 only thread 0
    cyc(2'b00, 1, 0, 0, 6'd0, 0, 0);       // R2 hold
    cyc(2'b10, 1, 0, 0, 6'd0, 0, 0);       // R3 entry with pulse
    cyc(2'b00, 1, 1, 0, 6'd0, 0, 0);       // R5 snoop
    cyc(2'b00, 1, 0, 0, 6'b000001, 0, 0);  // R10 wake ignored in snoop
    cyc(2'b00, 1, 0, 1, 6'd0, 0, 0);       // R5 return
    cyc(2'b00, 0, 0, 0, 6'd0, 0, 0);       // R6 HALT -> Stop-Grant
    cyc(2'b00, 0, 1, 0, 6'b100000, 0, 0);  // R7 snoop, wake ignored
    cyc(2'b00, 1, 0, 0, 6'd0, 0, 0);       // R7 stop-clock level ignored
    cyc(2'b00, 1, 0, 1, 6'd0, 0, 0);       // R7 back to Stop-Grant
    cyc(2'b00, 1, 0, 0, 6'd0, 0, 0);       // R6 back to HALT
    cyc(2'b00, 0, 0, 0, 6'b010000, 0, 0);  // R4 wake beats stop-clock
    cyc(2'b11, 1, 0, 0, 6'b001000, 0, 0);  // R4 wake beats strobes in running
    cyc(2'b11, 0, 0, 0, 6'd0, 0, 0);       // R6 stop-clock beats halt entry
    cyc(2'b00, 1, 0, 0, 6'd0, 0, 0);       // R6 back to running
    cyc(2'b00, 1, 0, 0, 6'b000010, 0, 0);  // R4 clear flags
    cyc(2'b00, 1, 0, 0, 6'd0, 1, 0);       // R8 resume to running: no effect
    cyc(2'b00, 1, 0, 0, 6'd0, 1, 1);       // R8 resume to HALT, no pulse
    cyc(2'b01, 1, 0, 0, 6'd0, 0, 0);       // R10 strobe in HALT ignored
    cyc(2'b00, 1, 0, 0, 6'b000100, 0, 0);  // R4 bus-init wake

    sc_lvl = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      logic [NTHR-1:0] th;
      logic [5:0] w;
      if (($urandom % 10) == 0) sc_lvl = ~sc_lvl;
      for (int t = 0; t < NTHR; t++) th[t] = (($urandom % 5) == 0);
      for (int b = 0; b < 6; b++) w[b] = (($urandom % 60) == 0);
      cyc(th, sc_lvl, (($urandom % 6) == 0), (($urandom % 4) == 0), w,
          (($urandom % 15) == 0), $urandom % 2);
      if (i == 2000) do_reset();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule